// File: doc/BRIEF.md
# Pixel Row Zero-Suppression Encoder

This block takes one row of binary hit flags from a pixel matrix and replaces it with a short list of words. Only the fired pixels are described. The row is split into fixed-width column banks. Inside each bank, runs of adjacent fired pixels are found. Each run is cut into pieces of at most four pixels, and each piece becomes one state word giving its first column and its length. A row with at least one fired pixel produces a header word first. The header gives the row address, the number of state words that follow, and a flag that is set when the row was truncated. An empty row produces nothing.

Truncation never stalls the input. Three caps apply:
- a per-bank cap on states in one row,
- a per-row cap on states in total,
- a per-frame cap on states stored since the last frame-start pulse.

A state that would exceed any cap is dropped. A bank or row cap that drops a state sets the header flag. The frame cap sets a sticky status output, which the next frame-start pulse clears together with the frame state counter.

Rows are accepted with a valid/ready pair. The block scans the row one column per cycle and holds the surviving states in a small buffer. It then drains the header and the states through a valid/ready output. No new row is accepted until the last word of the current row has been taken.

Top module: `pixrow_zs`

## Requirements
- R1: A row whose bits are all zero produces no output word, and `row_ready` returns high once the scan ends.
- R2: A state word has bit 15 = 0, bits 14:13 = 0, bits 12:11 = run length minus one, and bits 10:0 = the column of the run's first pixel. A run longer than four pixels is cut into four-pixel states from its low end, plus a final shorter state.
- R3: A run never spans two banks. A run that crosses a bank boundary ends at the last column of the lower bank and restarts at the first column of the upper bank.
- R4: At most BANK_CAP states (default 6) are kept from one bank of one row. Later runs in that bank are dropped.
- R5: At most ROW_CAP states (default 9) are kept per row across all banks. Later states are dropped, and the header count field never exceeds ROW_CAP.
- R6: A header word has bit 15 = 1, bit 14 = the truncation flag, bits 13:10 = the number of states that follow, and bits 9:0 = the row address. It is the first word of every non-empty row. The flag is 1 exactly when a bank cap or the row cap dropped a state of that row.
- R7: The states of a row come out in ascending column order: lower banks first, and lower columns first within a bank.
- R8: At most FRAME_CAP states (default 570) are kept between frame-start pulses. A state dropped by this cap sets the sticky `frame_ovf` output. A `frame_start` pulse clears the counter and `frame_ovf` on the next cycle.
- R9: `row_ready` goes low the cycle after a row is accepted. It stays low until the last word of that row has been transferred. While `out_valid` is high and `out_ready` is low, `out_word` holds steady.
- R10: After reset, `row_ready` = 1, `out_valid` = 0 and `frame_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame pulse; clears the frame counter and `frame_ovf` |
| row_valid | input | 1 | A row is offered |
| row_ready | output | 1 | The block can accept a row |
| row_addr | input | ROW_AW | Address of the offered row |
| row_bits | input | NCOL | Hit flags of the offered row, column 0 in bit 0 |
| out_valid | output | 1 | `out_word` holds a word |
| out_ready | input | 1 | The consumer takes the word |
| out_word | output | WORD_W | Header or state word |
| frame_ovf | output | 1 | Sticky flag: the frame cap dropped a state |

## Verification
The bench builds the encoder with a 64-column row split into four banks of 16 columns. This keeps the bank cap of 6 and the row cap of 9, and lowers the frame cap to 20. With these values, a single crafted row can hit the bank cap, the row cap, or both, and two or three dense rows are enough to exhaust a frame. Each row takes only 64 scan cycles, so several hundred random rows of mixed density fit in the run, with random backpressure on the output.

// File: rtl/pixrow_zs.sv
module pixrow_zs #(
  parameter int NCOL      = 1152,
  parameter int BANK_W    = 64,
  parameter int BANK_CAP  = 6,
  parameter int ROW_CAP   = 9,
  parameter int FRAME_CAP = 570,
  parameter int RUN_MAX   = 4,
  parameter int COL_AW    = 11,
  parameter int ROW_AW    = 10,
  parameter int CNT_W     = 4,
  localparam int LF_W     = $clog2(RUN_MAX),
  localparam int SW       = LF_W + COL_AW,
  localparam int HW       = 1 + CNT_W + ROW_AW,
  localparam int WORD_W   = 1 + ((SW > HW) ? SW : HW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              row_valid,
  output logic              row_ready,
  input  logic [ROW_AW-1:0] row_addr,
  input  logic [NCOL-1:0]   row_bits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              frame_ovf
);
  localparam int PTR_W  = $clog2(NCOL);
  localparam int BCOL_W = $clog2(BANK_W);
  localparam int BC_W   = $clog2(BANK_CAP + 1);
  localparam int RC_W   = $clog2(ROW_CAP + 1);
  localparam int FC_W   = $clog2(FRAME_CAP + 1);
  localparam int LEN_W  = $clog2(RUN_MAX + 1);

  typedef enum logic [1:0] {IDLE, SCAN, SEND} st_t;
  st_t st;

  logic [NCOL-1:0]   bits_q;
  logic [ROW_AW-1:0] addr_q;
  logic              anyhit_q;
  logic [PTR_W-1:0]  ptr;
  logic [BCOL_W-1:0] bcol;
  logic [LEN_W-1:0]  run_len;
  logic [COL_AW-1:0] run_start;
  logic [BC_W-1:0]   bcnt;
  logic [RC_W-1:0]   rcnt;
  logic [RC_W-1:0]   idx;
  logic [FC_W-1:0]   fcnt;
  logic              rovf;
  logic [SW-1:0]     sbuf [ROW_CAP];

  logic              hit, last_b, last_c, close_hit, close_gap, emit, store;
  logic              full_b, full_r, full_f;
  logic [LEN_W-1:0]  new_len, e_len;
  logic [COL_AW-1:0] e_start;

  assign hit       = bits_q[ptr];
  assign last_b    = bcol == BCOL_W'(BANK_W - 1);
  assign last_c    = ptr == PTR_W'(NCOL - 1);
  assign new_len   = run_len + 1'b1;
  assign close_hit = hit && (new_len == LEN_W'(RUN_MAX) || last_b);
  assign close_gap = !hit && run_len != '0;
  assign emit      = (st == SCAN) && (close_hit || close_gap);
  assign e_start   = (hit && run_len == '0) ? COL_AW'(ptr) : run_start;
  assign e_len     = hit ? new_len : run_len;
  assign full_b    = bcnt >= BC_W'(BANK_CAP);
  assign full_r    = rcnt >= RC_W'(ROW_CAP);
  assign full_f    = fcnt >= FC_W'(FRAME_CAP);
  assign store     = emit && !full_b && !full_r && !full_f;

  assign row_ready = st == IDLE;
  assign out_valid = st == SEND;

  always_comb begin
    out_word = '0;
    if (idx == '0) begin
      out_word[WORD_W-1]          = 1'b1;
      out_word[ROW_AW-1:0]        = addr_q;
      out_word[ROW_AW +: CNT_W]   = CNT_W'(rcnt);
      out_word[ROW_AW + CNT_W]    = rovf;
    end else begin
      out_word[SW-1:0] = sbuf[RC_W'(idx - 1'b1)];
    end
  end

  always_ff @(posedge clk) begin
    if (store) sbuf[rcnt] <= {LF_W'(e_len - 1'b1), e_start};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt      <= '0;
      frame_ovf <= 1'b0;
    end else if (frame_start) begin
      fcnt      <= '0;
      frame_ovf <= 1'b0;
    end else begin
      if (store) fcnt <= fcnt + 1'b1;
      if (emit && full_f) frame_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      bits_q    <= '0;
      addr_q    <= '0;
      anyhit_q  <= 1'b0;
      ptr       <= '0;
      bcol      <= '0;
      run_len   <= '0;
      run_start <= '0;
      bcnt      <= '0;
      rcnt      <= '0;
      idx       <= '0;
      rovf      <= 1'b0;
    end else begin
      case (st)
        IDLE: if (row_valid) begin
          bits_q   <= row_bits;
          addr_q   <= row_addr;
          anyhit_q <= |row_bits;
          ptr      <= '0;
          bcol     <= '0;
          run_len  <= '0;
          bcnt     <= '0;
          rcnt     <= '0;
          idx      <= '0;
          rovf     <= 1'b0;
          st       <= SCAN;
        end
        SCAN: begin
          ptr  <= ptr + 1'b1;
          bcol <= last_b ? '0 : bcol + 1'b1;
          if (close_hit) run_len <= '0;
          else if (hit) begin
            run_len <= new_len;
            if (run_len == '0) run_start <= COL_AW'(ptr);
          end else run_len <= '0;
          bcnt <= last_b ? '0 : bcnt + BC_W'(store);
          rcnt <= rcnt + RC_W'(store);
          if (emit && (full_b || full_r)) rovf <= 1'b1;
          if (last_c) st <= anyhit_q ? SEND : IDLE;
        end
        SEND: if (out_ready) begin
          if (idx == rcnt) st <= IDLE;
          else idx <= idx + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pixrow_zs_chk.sv
module pixrow_zs_chk #(
  parameter int WORD_W  = 16,
  parameter int ROW_AW  = 10,
  parameter int CNT_W   = 4,
  parameter int ROW_CAP = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              row_valid,
  input logic              row_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              frame_ovf
);
  a_r9_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !row_ready);

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && row_ready |=> !row_ready);

  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  a_r6_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_word[WORD_W-1]);

  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[WORD_W-1] |-> out_word[ROW_AW +: CNT_W] <= CNT_W'(ROW_CAP));

  a_r8_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_ovf);
endmodule

bind pixrow_zs pixrow_zs_chk #(
  .WORD_W(WORD_W), .ROW_AW(ROW_AW), .CNT_W(CNT_W), .ROW_CAP(ROW_CAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_valid(row_valid),
  .row_ready(row_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .frame_ovf(frame_ovf)
);

// File: tb/pixrow_zs_tb.sv
module pixrow_zs_tb;
  localparam int NCOL = 64;
  localparam int BANK_W = 16;
  localparam int NB = NCOL / BANK_W;
  localparam int FCAP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        row_valid = 1'b0;
  logic        row_ready;
  logic [9:0]  row_addr = '0;
  logic [63:0] row_bits = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_word;
  logic        frame_ovf;

  int n_chk = 0, n_fail = 0;
  int m_fc = 0;
  bit m_fovf = 0;
  logic [15:0] exp_w [0:15];
  int exp_n;

  always #10 clk = ~clk;

  pixrow_zs #(.NCOL(NCOL), .BANK_W(BANK_W), .FRAME_CAP(FCAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_valid(row_valid),
    .row_ready(row_ready), .row_addr(row_addr), .row_bits(row_bits),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .frame_ovf(frame_ovf));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] r, input logic [9:0] a);
    int rc, bc, c, s, l;
    bit ro;
    rc = 0; ro = 0; exp_n = 0;
    for (int b = 0; b < NB; b++) begin
      bc = 0; c = 0;
      while (c < BANK_W) begin
        if (r[b*BANK_W + c]) begin
          s = c; l = 0;
          while (c < BANK_W && r[b*BANK_W + c] && l < 4) begin l++; c++; end
          if (bc >= 6 || rc >= 9) ro = 1;
          if (m_fc >= FCAP) m_fovf = 1;
          if (bc < 6 && rc < 9 && m_fc < FCAP) begin
            exp_w[1 + rc] = {3'b000, 2'(l - 1), 11'(b*BANK_W + s)};
            bc++; rc++; m_fc++;
          end
        end else c++;
      end
    end
    if (r != '0) begin
      exp_w[0] = {1'b1, ro, 4'(rc), a};
      exp_n = 1 + rc;
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    m_fc = 0; m_fovf = 0;
    chk("R8 frame_ovf cleared", 32'(frame_ovf), 0);
  endtask

  task automatic run_row(input logic [63:0] r, input logic [9:0] a, input string tag);
    int k, guard;
    bit stall;
    logic [15:0] held;
    model(r, a);
    @(negedge clk);
    row_bits = r; row_addr = a; row_valid = 1'b1;
    @(negedge clk);
    row_valid = 1'b0;
    chk({tag, " R9 busy after accept"}, 32'(row_ready), 0);
    k = 0; guard = 0; stall = 0;
    while (!row_ready && guard < 2000) begin
      out_ready = ($urandom % 4) != 0;
      if (stall) chk("R9 stall hold", {15'd0, out_valid, out_word}, {15'd0, 1'b1, held});
      stall = out_valid && !out_ready;
      held = out_word;
      if (out_valid && out_ready) begin
        if (k < exp_n)
          chk(k == 0 ? {tag, " R6 header"} : {tag, " R7 R2 state"}, 32'(out_word), 32'(exp_w[k]));
        else chk({tag, " R1 extra word"}, 32'(out_word), 32'hFFFF_FFFF);
        k++;
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
    chk({tag, " word count"}, 32'(k), 32'(exp_n));
    chk({tag, " R8 frame_ovf"}, 32'(frame_ovf), 32'(m_fovf));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] r;
    int d;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R10 row_ready", 32'(row_ready), 1);
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 frame_ovf", 32'(frame_ovf), 0);
    rst_n = 1'b1;
    pulse_frame();
    run_row(64'h0, 10'h155, "R1 empty");
    run_row(64'h0000_0000_0000_FFFF, 10'h001, "R2 full bank");
    run_row(64'h0000_0000_0000_00FC, 10'h002, "R2 run of six");
    run_row(64'h0000_0000_0007_E000, 10'h003, "R3 cross bank");
    run_row(64'h0000_0000_5555_0000, 10'h004, "R4 bank cap");
    pulse_frame();
    run_row(64'h0000_0001_0015_0555, 10'h3FF, "R5 row cap");
    run_row(64'h0000_0005_0005_5555, 10'h005, "R5 R4 both caps");
    run_row(64'h0000_0005_0005_5555, 10'h006, "R8 frame cap");
    pulse_frame();
    run_row(64'h8000_0000_0000_0001, 10'h007, "R8 after clear");
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 5 == 0) pulse_frame();
      d = $urandom % 4;
      for (int c = 0; c < 64; c++) begin
        case (d)
          0: r[c] = ($urandom % 16) == 0;
          1: r[c] = ($urandom % 4) == 0;
          2: r[c] = ($urandom % 2) == 0;
          default: r[c] = ($urandom % 4) != 0;
        endcase
      end
      if ($urandom % 10 == 0) r = '0;
      run_row(r, 10'($urandom), "random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule